// File: doc/BRIEF.md
# Asynchronous SRAM Write Timing Checker

This block is a passive, synthesizable observer for the pins of an asynchronous static RAM. It runs from a fast sampling clock whose period is known. It watches:

- the active-low chip enable and the active-high second select;
- the active-low write strobe and the two active-low byte lanes;
- the active-low output enable;
- the 20-bit address and the 16-bit data bus.

From these lines it rebuilds each write. A write is framed by whichever strobe is the last to open the window and whichever strobe is the first to close it. Each write is then measured against a set of minimum intervals, all counted in sample-clock cycles.

Every violated rule sets its own sticky flag. A one-cycle pulse marks each sample in which any new violation is found. A free-running counter reports how many writes have finished. The monitor never drives the memory bus, and it adds nothing to the memory's own timing.

All pins pass through the same two-flop synchronizer. Every interval is therefore measured between samples that carry the same fixed delay, so the thresholds need no correction for that pipeline. The outputs lag the pins by three sample edges.

Top module: `sram_wr_monitor`

## Requirements
- R1: After a synchronous reset, `viol_flags`, `viol_pulse` and `write_count` are all zero.
- R2: A write window is open in every sample where `sel2_i` is 1, `ce_n_i` is 0, `we_n_i` is 0, and at least one of `ub_n_i`/`lb_n_i` is 0. `write_count` increases by exactly one for each sample in which a window closes, whether or not any rule was broken. When `sel2_i` is 0, no window exists.
- R3: Flag bit 0 (overlap) is set when a window closes after fewer than `MIN_OVERLAP` open samples.
- R4: Flag bit 1 (strobe width) is set when `we_n_i` rises after a low pulse of fewer than `MIN_WE_LOW` samples, during which a window was open.
- R5: Flag bit 2 (data setup) is set when the data bus has held its value for fewer than `MIN_DATA_SETUP` consecutive samples just before the closing sample.
- R6: Flag bit 3 (address setup) is set when the address has held its value for fewer than `MIN_ADDR_SETUP` consecutive samples just before the closing sample.
- R7: Flag bit 4 (address hold) is set when the address changes in a sample where the window was already open in the previous sample. An address change in the sample that opens the window is not counted here.
- R8: Flag bit 5 (cycle spacing) is set when a window opens fewer than `MIN_CYCLE` samples after the previous opening. The first window after reset is never flagged.
- R9: Flag bit 6 (contention warning) is set when `oe_n_i` is 0 in the sample that opens a window.
- R10: Flags are sticky. A flag stays set until `clr_i` is high at a clock edge, and `clr_i` clears all flags. A violation found in the same cycle as `clr_i` still sets its flag.
- R11: `viol_pulse` is high for exactly one cycle for each sample that raised at least one violation. It rises on the same edge as the matching flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of all sticky flags |
| ce_n_i | input | 1 | Memory chip enable, active low |
| sel2_i | input | 1 | Memory second select, active high |
| we_n_i | input | 1 | Memory write strobe, active low |
| ub_n_i | input | 1 | Upper byte lane enable, active low |
| lb_n_i | input | 1 | Lower byte lane enable, active low |
| oe_n_i | input | 1 | Memory output enable, active low |
| addr_i | input | 20 | Memory address lines |
| data_i | input | 16 | Memory data lines |
| viol_flags | output | 7 | Sticky per-rule violation flags (bit order as in R3 to R9) |
| viol_pulse | output | 1 | One-cycle marker of a new violation |
| write_count | output | 16 | Number of completed writes, wrapping |

## Verification
The assertions assume that the memory pins change only between sample edges. They also assume that reset is held long enough to flush the synchronizer before any window opens. The bench therefore changes every pin on the falling clock edge and keeps the bus idle for several cycles after reset.

The assertions further assume that `clr_i` is a clean synchronous pulse. The bench drives it only on falling edges.

Each scenario is built sample by sample, so that a window length, a strobe width or a run of stable address or data lands exactly one sample either side of its threshold. The bench overrides the thresholds so that each rule can fail on its own, without a neighbouring rule failing with it.

// File: rtl/sram_wr_monitor_pkg.sv
`timescale 1ns/1ps
package sram_wr_monitor_pkg;
  // Flag bit positions; the bench and downstream logic decode these.
  localparam int RULE_OVERLAP   = 0;
  localparam int RULE_WE_WIDTH  = 1;
  localparam int RULE_DATA_SU   = 2;
  localparam int RULE_ADDR_SU   = 3;
  localparam int RULE_ADDR_HOLD = 4;
  localparam int RULE_SPACING   = 5;
  localparam int RULE_CONTEND   = 6;
  localparam int NRULES         = 7;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_wr_monitor_sync.sv
`timescale 1ns/1ps
module sram_wr_monitor_sync #(
  parameter int          W      = 8,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sram_wr_monitor_run.sv
`timescale 1ns/1ps
// Saturating run-length counter: restart loads 1, advance adds 1, otherwise holds.
module sram_wr_monitor_run #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         advance,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (restart)               cnt <= W'(1);
    else if (advance && cnt != SAT) cnt <= cnt + W'(1);
  end

  // R3..R8 all rely on a counter that never wraps back to a small value
  a_r3_run_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt == SAT && !restart) |=> cnt == SAT);
  a_r3_run_restart: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt == W'(1));
endmodule

// File: rtl/sram_wr_monitor.sv
`timescale 1ns/1ps
module sram_wr_monitor
  import sram_wr_monitor_pkg::*;
#(
  parameter int AW             = 20,
  parameter int DW             = 16,
  parameter int CNT_W          = 16,
  parameter int SYNC_STAGES    = 2,
  parameter int MIN_OVERLAP    = 6,
  parameter int MIN_WE_LOW     = 5,
  parameter int MIN_DATA_SETUP = 3,
  parameter int MIN_ADDR_SETUP = 6,
  parameter int MIN_CYCLE      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              ce_n_i,
  input  logic              sel2_i,
  input  logic              we_n_i,
  input  logic              ub_n_i,
  input  logic              lb_n_i,
  input  logic              oe_n_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  output logic [NRULES-1:0] viol_flags,
  output logic              viol_pulse,
  output logic [CNT_W-1:0]  write_count
);
  localparam int TMAX = max_of(max_of(max_of(MIN_OVERLAP, MIN_WE_LOW),
                                      max_of(MIN_DATA_SETUP, MIN_ADDR_SETUP)),
                               MIN_CYCLE);
  localparam int TW = $clog2(TMAX + 1) + 1;
  localparam int SW = 6 + AW + DW;
  localparam logic [SW-1:0] IDLE = {1'b0, 5'b11111, {(AW+DW){1'b0}}};
  localparam logic [TW-1:0] T_OVL  = TW'(MIN_OVERLAP);
  localparam logic [TW-1:0] T_WE   = TW'(MIN_WE_LOW);
  localparam logic [TW-1:0] T_DSU  = TW'(MIN_DATA_SETUP);
  localparam logic [TW-1:0] T_ASU  = TW'(MIN_ADDR_SETUP);
  localparam logic [TW-1:0] T_CYC  = TW'(MIN_CYCLE);

  // Every pin goes through the same synchronizer, so intervals between
  // samples equal intervals at the pins: the pipeline adjustment is zero.
  logic [SW-1:0] raw, syn;
  assign raw = {sel2_i, oe_n_i, lb_n_i, ub_n_i, we_n_i, ce_n_i, addr_i, data_i};

  sram_wr_monitor_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  logic          s_sel2, s_oe_n, s_lb_n, s_ub_n, s_we_n, s_ce_n;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;
  assign {s_sel2, s_oe_n, s_lb_n, s_ub_n, s_we_n, s_ce_n, s_addr, s_data} = syn;

  // Previous-sample state
  logic          win_q, we_n_q, saw_win, had_start;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  logic win, win_open, win_close, we_fall, we_rise, addr_chg, data_chg;
  assign win       = s_sel2 & ~s_ce_n & ~s_we_n & ~(s_ub_n & s_lb_n);
  assign win_open  = win & ~win_q;
  assign win_close = ~win & win_q;
  assign we_fall   = ~s_we_n & we_n_q;
  assign we_rise   = s_we_n & ~we_n_q;
  assign addr_chg  = s_addr != addr_q;
  assign data_chg  = s_data != data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q     <= 1'b0;
      we_n_q    <= 1'b1;
      saw_win   <= 1'b0;
      had_start <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      win_q     <= win;
      we_n_q    <= s_we_n;
      saw_win   <= we_fall ? win : (saw_win | win);
      had_start <= had_start | win_open;
      addr_q    <= s_addr;
      data_q    <= s_data;
    end
  end

  // Run lengths, in samples, each ending at the previous sample
  logic [TW-1:0] win_len, we_len, d_run, a_run, gap;

  sram_wr_monitor_run #(.W(TW)) u_win_len (
    .clk(clk), .rst(rst), .restart(win_open), .advance(win), .cnt(win_len));
  sram_wr_monitor_run #(.W(TW)) u_we_len (
    .clk(clk), .rst(rst), .restart(we_fall), .advance(~s_we_n), .cnt(we_len));
  sram_wr_monitor_run #(.W(TW)) u_d_run (
    .clk(clk), .rst(rst), .restart(data_chg), .advance(1'b1), .cnt(d_run));
  sram_wr_monitor_run #(.W(TW)) u_a_run (
    .clk(clk), .rst(rst), .restart(addr_chg), .advance(1'b1), .cnt(a_run));
  sram_wr_monitor_run #(.W(TW)) u_gap (
    .clk(clk), .rst(rst), .restart(win_open), .advance(1'b1), .cnt(gap));

  logic [NRULES-1:0] new_v;
  always_comb begin
    new_v                 = '0;
    new_v[RULE_OVERLAP]   = win_close && (win_len < T_OVL);
    new_v[RULE_WE_WIDTH]  = we_rise && saw_win && (we_len < T_WE);
    new_v[RULE_DATA_SU]   = win_close && (d_run < T_DSU);
    new_v[RULE_ADDR_SU]   = win_close && (a_run < T_ASU);
    new_v[RULE_ADDR_HOLD] = win && win_q && addr_chg;
    new_v[RULE_SPACING]   = win_open && had_start && (gap < T_CYC);
    new_v[RULE_CONTEND]   = win_open && !s_oe_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_flags  <= '0;
      viol_pulse  <= 1'b0;
      write_count <= '0;
    end else begin
      viol_flags  <= (clr_i ? '0 : viol_flags) | new_v;
      viol_pulse  <= |new_v;
      write_count <= write_count + CNT_W'(win_close);
    end
  end

  // R2: each closing sample adds exactly one completed write
  a_r2_count_on_close: assert property (@(posedge clk) disable iff (rst)
    win_close |=> write_count == $past(write_count) + CNT_W'(1));
  a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
    !win_close |=> write_count == $past(write_count));
  // R7: address movement inside an open window is always recorded
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (win && win_q && addr_chg) |=> viol_flags[RULE_ADDR_HOLD]);
  // R10: a clear with nothing new leaves all flags low
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && new_v == '0) |=> viol_flags == '0);
  // R11: a pulse always comes with at least one flag
  a_r11_pulse_flag: assert property (@(posedge clk) disable iff (rst)
    viol_pulse |-> viol_flags != '0);

  generate
    for (genvar i = 0; i < NRULES; i++) begin : g_sticky
      // R10: a set flag survives every cycle without a clear
      a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (viol_flags[i] && !clr_i) |=> viol_flags[i]);
    end
  endgenerate
endmodule

// File: tb/sram_wr_monitor_bench.sv
`timescale 1ns/1ps
module sram_wr_monitor_bench;
  logic        clk = 1'b0;
  logic        rst, clr_i, ce_n_i, sel2_i, we_n_i, ub_n_i, lb_n_i, oe_n_i;
  logic [19:0] addr_i;
  logic [15:0] data_i;
  logic [6:0]  viol_flags;
  logic        viol_pulse;
  logic [15:0] write_count;

  int checks = 0;
  int fails  = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sram_wr_monitor #(
    .MIN_OVERLAP(3), .MIN_WE_LOW(5), .MIN_DATA_SETUP(2),
    .MIN_ADDR_SETUP(5), .MIN_CYCLE(6)
  ) u_sram_wr_monitor (
    .clk(clk), .rst(rst), .clr_i(clr_i), .ce_n_i(ce_n_i), .sel2_i(sel2_i),
    .we_n_i(we_n_i), .ub_n_i(ub_n_i), .lb_n_i(lb_n_i), .oe_n_i(oe_n_i),
    .addr_i(addr_i), .data_i(data_i), .viol_flags(viol_flags),
    .viol_pulse(viol_pulse), .write_count(write_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobes(input logic v);
    ce_n_i = v; we_n_i = v; ub_n_i = v; lb_n_i = v;
  endtask

  task automatic clear_flags();
    clr_i = 1'b1; cyc(1); clr_i = 1'b0; cyc(1);
  endtask

  task automatic settle_check(input string tag, input int exp_flags);
    cyc(5);
    chk({tag, " flags"}, int'(viol_flags), exp_flags);
    chk({tag, " count"}, int'(write_count), exp_cnt);
    clear_flags();
  endtask

  task automatic t_reset();
    rst = 1'b1; clr_i = 1'b0; sel2_i = 1'b1; oe_n_i = 1'b1;
    strobes(1'b1); addr_i = 20'h00100; data_i = 16'h1234;
    cyc(4); rst = 1'b0; cyc(8);
    chk("R1 flags", int'(viol_flags), 0);
    chk("R1 pulse", int'(viol_pulse), 0);
    chk("R1 count", int'(write_count), 0);
  endtask

  task automatic t_good();
    addr_i = 20'h0ABCD; data_i = 16'h5A5A; cyc(6);
    strobes(1'b0); cyc(6); strobes(1'b1); exp_cnt++;
    settle_check("R2 clean write", 0);
  endtask

  task automatic t_sel_low();
    sel2_i = 1'b0; strobes(1'b0); cyc(6); strobes(1'b1); cyc(2); sel2_i = 1'b1;
    settle_check("R2 second select low", 0);
  endtask

  task automatic t_overlap();
    we_n_i = 1'b0; cyc(1);
    ce_n_i = 1'b0; lb_n_i = 1'b0; cyc(2);
    ce_n_i = 1'b1; lb_n_i = 1'b1; exp_cnt++; cyc(2);
    we_n_i = 1'b1;
    settle_check("R3 short overlap", 1);
  endtask

  task automatic t_we_width();
    ce_n_i = 1'b0; lb_n_i = 1'b0; cyc(1);
    we_n_i = 1'b0; cyc(4); we_n_i = 1'b1; exp_cnt++; cyc(1);
    ce_n_i = 1'b1; lb_n_i = 1'b1;
    settle_check("R4 short strobe", 2);
  endtask

  task automatic t_data_setup();
    strobes(1'b0); cyc(5);
    data_i = 16'hC3C3; cyc(1);
    strobes(1'b1); exp_cnt++;
    cyc(3);
    chk("R11 pulse high", int'(viol_pulse), 1);
    chk("R5 late data", int'(viol_flags), 4);
    cyc(1);
    chk("R11 pulse one cycle", int'(viol_pulse), 0);
    cyc(6);
    chk("R10 flag sticky", int'(viol_flags), 4);
    clr_i = 1'b1; cyc(1); clr_i = 1'b0;
    chk("R10 clear", int'(viol_flags), 0);
    cyc(4);
    // boundary: exactly MIN_DATA_SETUP stable samples
    strobes(1'b0); cyc(4);
    data_i = 16'h0F0F; cyc(2);
    strobes(1'b1); exp_cnt++;
    settle_check("R5 data boundary", 0);
  endtask

  task automatic t_addr_setup();
    we_n_i = 1'b0; cyc(1);
    ce_n_i = 1'b0; lb_n_i = 1'b0; addr_i = 20'h11111; cyc(4);
    ce_n_i = 1'b1; lb_n_i = 1'b1; exp_cnt++; cyc(1);
    we_n_i = 1'b1;
    settle_check("R6 late address", 8);
    cyc(4);
    we_n_i = 1'b0; addr_i = 20'h22222; cyc(1);
    ce_n_i = 1'b0; lb_n_i = 1'b0; cyc(4);
    ce_n_i = 1'b1; lb_n_i = 1'b1; exp_cnt++; cyc(1);
    we_n_i = 1'b1;
    settle_check("R6 address boundary", 0);
  endtask

  task automatic t_addr_hold();
    cyc(4);
    strobes(1'b0); cyc(1);
    addr_i = 20'h33333; cyc(5);
    strobes(1'b1); exp_cnt++;
    settle_check("R7 address moved in window", 16);
  endtask

  task automatic t_spacing(input int gap_cycles, input int exp_flags, input string tag);
    cyc(4);
    ce_n_i = 1'b0; we_n_i = 1'b0; cyc(1);
    lb_n_i = 1'b0; cyc(3); lb_n_i = 1'b1; exp_cnt++; cyc(gap_cycles);
    lb_n_i = 1'b0; cyc(3); lb_n_i = 1'b1; exp_cnt++; cyc(1);
    ce_n_i = 1'b1; we_n_i = 1'b1;
    settle_check(tag, exp_flags);
  endtask

  task automatic t_contention();
    oe_n_i = 1'b0; cyc(6);
    strobes(1'b0); cyc(6); strobes(1'b1); exp_cnt++;
    oe_n_i = 1'b1;
    settle_check("R9 output enabled at start", 64);
  endtask

  task automatic t_clear_race();
    oe_n_i = 1'b0; cyc(6);
    strobes(1'b0); cyc(2);
    clr_i = 1'b1; cyc(1); clr_i = 1'b0;
    chk("R10 set wins over clear", int'(viol_flags), 64);
    cyc(4); strobes(1'b1); exp_cnt++; oe_n_i = 1'b1;
    settle_check("R10 after race", 64);
  endtask

  initial begin
    t_reset();
    t_good();
    t_sel_low();
    t_overlap();
    t_we_width();
    t_data_setup();
    t_addr_setup();
    t_addr_hold();
    t_spacing(2, 32, "R8 starts too close");
    t_spacing(3, 0, "R8 spacing boundary");
    t_contention();
    t_clear_race();
    t_good();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule